// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the protocol engine on the target side of a two-wire serial memory holding 64K bytes. It takes the bus clock and data lines as plain inputs, oversampled by the system clock, and answers on the data line through an open-drain enable. When the enable is high, the pad pulls the line low. Otherwise the line floats high through the bus pull-up. The engine finds start and stop conditions and shifts bytes in and out. It checks the device address byte against two strap pins and keeps a 16-bit word address counter.

Storage sits outside the block. A synchronous RAM is read through an address and data port with one cycle of latency. Writes leave the block as single-cycle requests carrying an address and a data byte, toward a page buffer. A busy input from the write machinery makes the engine withhold its address acknowledge, which gives controllers a way to poll until a write has finished.

The engine supports byte and multi-byte writes, current-address reads, random reads and sequential reads. A random read is a write header with no data, followed by a repeated start.

Top module: `eet_target`

## Requirements
- R1: A falling data line while the clock line is high is a start. A start at any point abandons the transfer in progress, releases the data line and begins device-address reception. A rising data line while the clock line is high is a stop. A stop returns the engine to idle with the data line released.
- R2: The device address byte is sent MSB first. Its bits 7..3 must be 1,0,1,0,0, bits 2..1 must equal `strap_i[1:0]`, and bit 0 selects the direction (1 = read, 0 = write). On a match the engine pulls the data line low for the whole ninth clock.
- R3: On an address mismatch the engine does not acknowledge. It then ignores all further clocks (no acknowledges, no write requests) until the next start.
- R4: While `busy_i` is high when the eighth address bit arrives, the device address is not acknowledged. Once busy is low, the address is acknowledged normally.
- R5: A write header carries two word-address bytes, high byte first, and each one is acknowledged. Together they set the 16-bit word address counter.
- R6: Each data byte received after the header is acknowledged. It produces a one-cycle `wr_req_o` carrying the current counter value and the byte, and the counter then advances.
- R7: During writes only the low 7 counter bits advance, wrapping inside the 128-byte page. For example, writes starting at 0x207E go to 0x207E, 0x207F and then 0x2000.
- R8: After an acknowledged read address, the engine sends the byte stored at the counter, MSB first. Each bit changes only while the clock line is low. Each byte sent advances the counter by one, so a current-address read returns the byte after the last one accessed.
- R9: A write header with no data followed by a repeated start and a read address returns the byte at the address just loaded.
- R10: While the controller acknowledges (low on the ninth clock), the engine keeps sending successive bytes. The address wraps from 0xFFFF to 0x0000.
- R11: A not-acknowledge (high on the ninth clock) ends the read. The data line then stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Device address strap pins |
| busy_i | input | 1 | High while an internal write cycle runs |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| rd_addr_o | output | 16 | Read address to the synchronous RAM |
| rd_data_i | input | 8 | RAM read data, valid one cycle after the address |
| wr_req_o | output | 1 | One-cycle write request |
| wr_addr_o | output | 16 | Write request address |
| wr_data_o | output | 8 | Write request data |

## Verification
The assertions assume that the bus clock is slow enough for every level to stay stable for several system clocks after synchronisation. They also assume that the controller moves the data line only while the clock line is low, except when it makes a start or a stop. With these assumptions, the open-drain enable only changes while the synchronised clock line is low, and the bus events never coincide. The bench drives each bus quarter-period as ten system clocks and changes data only in the low phase. It never issues a start while the engine is pulling the line low, so the stimulus stays inside these assumptions.

// File: rtl/eet_pkg.sv
package eet_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] DEV_PREFIX = 5'b10100;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT,
        S_TACK, S_TX, S_TX_END, S_MACK, S_RNEXT
    } eng_state_t;

    typedef enum logic [1:0] {
        CTR_HOLD, CTR_LOAD, CTR_INC_ALL, CTR_INC_PAGE
    } ctr_op_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic high;
        logic sda;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [1:0] strap);
        return (b[7:3] == DEV_PREFIX) && (b[2:1] == strap);
    endfunction

endpackage

// File: rtl/eet_bus_sync.sv
module eet_bus_sync
    import eet_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int PW = STAGES + 1;

    logic [1:0] raw, cur, prv;
    assign raw = {sda_i, scl_i};

    for (genvar ln = 0; ln < 2; ln++) begin : g_line
        logic [PW-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '1;
            else     pipe <= {pipe[PW-2:0], raw[ln]};
        end
        assign cur[ln] = pipe[STAGES-1];
        assign prv[ln] = pipe[STAGES];
    end

    always_comb begin
        ev.rise  = cur[0] & ~prv[0];
        ev.fall  = ~cur[0] & prv[0];
        ev.high  = cur[0];
        ev.sda   = cur[1];
        ev.start = cur[0] & prv[0] & prv[1] & ~cur[1];
        ev.stop  = cur[0] & prv[0] & ~prv[1] & cur[1];
    end

    // R1
    ev_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev.rise, ev.fall, ev.start, ev.stop}));

endmodule

// File: rtl/eet_addr_ctr.sv
module eet_addr_ctr
    import eet_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  ctr_op_t           op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ctr
);
    localparam logic [ADDR_W-1:0]    ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [PAGE_BITS-1:0] ONE_P = {{(PAGE_BITS-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr <= '0;
        end else begin
            case (op)
                CTR_LOAD:     ctr <= load_val;
                CTR_INC_ALL:  ctr <= ctr + ONE_A;
                CTR_INC_PAGE: ctr[PAGE_BITS-1:0] <= ctr[PAGE_BITS-1:0] + ONE_P;
                default:      ctr <= ctr;
            endcase
        end
    end

endmodule

// File: rtl/eet_target.sv
module eet_target
    import eet_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam int          HI_W     = ADDR_W - BYTE_W;
    localparam logic [3:0]  LAST_BIT = 4'(BYTE_W - 1);

    bus_ev_t           ev;
    eng_state_t        st, nxt;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg, txreg, byte_in;
    logic [HI_W-1:0]   hi_q;
    logic              ack_on;
    logic              byte_end;
    ctr_op_t           ctr_op;
    logic [ADDR_W-1:0] ctr_q;

    eet_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    eet_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) ctr_i (
        .clk(clk), .rst(rst), .op(ctr_op),
        .load_val({hi_q, byte_in}), .ctr(ctr_q)
    );

    assign byte_in   = {shreg[BYTE_W-2:0], ev.sda};
    assign byte_end  = ev.rise && (bitcnt == LAST_BIT);
    assign rd_addr_o = ctr_q;

    always_comb begin
        ctr_op = CTR_HOLD;
        if (!ev.start && !ev.stop) begin
            if (byte_end && st == S_ALO)  ctr_op = CTR_LOAD;
            if (byte_end && st == S_WDAT) ctr_op = CTR_INC_PAGE;
            if (ev.fall && ((st == S_TACK && ack_on && nxt == S_TX) || st == S_RNEXT))
                ctr_op = CTR_INC_ALL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            nxt       <= S_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '1;
            hi_q      <= '0;
            ack_on    <= 1'b0;
            wr_req_o  <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_req_o <= 1'b0;
            if (ev.start) begin
                st     <= S_DEV;
                bitcnt <= '0;
                ack_on <= 1'b0;
            end else if (ev.stop) begin
                st     <= S_IDLE;
                ack_on <= 1'b0;
            end else begin
                case (st)
                    S_DEV, S_AHI, S_ALO, S_WDAT: if (ev.rise) begin
                        shreg  <= byte_in;
                        bitcnt <= bitcnt + 4'd1;
                        if (byte_end) begin
                            bitcnt <= '0;
                            st     <= S_TACK;
                            ack_on <= 1'b0;
                            case (st)
                                S_DEV: begin
                                    if (!dev_hit(byte_in, strap_i) || busy_i) st <= S_IDLE;
                                    nxt <= byte_in[0] ? S_TX : S_AHI;
                                end
                                S_AHI: begin
                                    hi_q <= byte_in[HI_W-1:0];
                                    nxt  <= S_ALO;
                                end
                                S_ALO: nxt <= S_WDAT;
                                default: begin
                                    wr_req_o  <= 1'b1;
                                    wr_addr_o <= ctr_q;
                                    wr_data_o <= byte_in;
                                    nxt       <= S_WDAT;
                                end
                            endcase
                        end
                    end
                    S_TACK: if (ev.fall) begin
                        if (!ack_on) begin
                            ack_on <= 1'b1;
                        end else begin
                            ack_on <= 1'b0;
                            st     <= nxt;
                            bitcnt <= '0;
                            if (nxt == S_TX) txreg <= rd_data_i;
                        end
                    end
                    S_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == LAST_BIT) st <= S_TX_END;
                        end else if (ev.fall) begin
                            txreg <= {txreg[BYTE_W-2:0], 1'b1};
                        end
                    end
                    S_TX_END: if (ev.fall) st <= S_MACK;
                    S_MACK:   if (ev.rise) st <= ev.sda ? S_IDLE : S_RNEXT;
                    S_RNEXT:  if (ev.fall) begin
                        txreg  <= rd_data_i;
                        bitcnt <= '0;
                        st     <= S_TX;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = (st == S_TACK && ack_on) ||
                      ((st == S_TX || st == S_TX_END) && !txreg[BYTE_W-1]);

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe_o);
    // R4
    busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEV && byte_end && busy_i && !ev.start && !ev.stop) |=> st == S_IDLE);
    // R6
    wr_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> $past(ev.rise));
    // R7
    page_keep_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> ctr_q[ADDR_W-1:PAGE_BITS] == wr_addr_o[ADDR_W-1:PAGE_BITS]);
    // R8
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !ev.high);

endmodule

// File: tb/eet_target_tb_top.sv
module eet_target_tb_top;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        bm_sda = 1'b1;
    logic        busy = 1'b0;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe, wr_req;
    logic [15:0] rd_addr, wr_addr;
    logic [7:0]  rd_q, wr_data;
    wire         line = bm_sda & ~sda_oe;

    int checks = 0, fails = 0, wr_cnt = 0;
    bit done = 0;
    logic [7:0] mem [int];
    logic [15:0] wa_log [8];

    always #10 clk = ~clk;

    eet_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .strap_i(strap),
        .busy_i(busy), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr), .rd_data_i(rd_q),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    function automatic logic [7:0] fill(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] mval(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : fill(a);
    endfunction

    always @(posedge clk) rd_q <= mval(rd_addr);
    always @(negedge clk) if (!rst && wr_req) begin
        mem[int'(wr_addr)] = wr_data;
        if (wr_cnt < 8) wa_log[wr_cnt] = wr_addr;
        wr_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        bm_sda = 1'b1; qw(); scl = 1'b1; qw(); bm_sda = 1'b0; qw(); scl = 1'b0; qw();
    endtask
    task automatic bus_stop();
        bm_sda = 1'b0; qw(); scl = 1'b1; qw(); bm_sda = 1'b1; qw();
    endtask
    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            bm_sda = b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        end
    endtask
    task automatic send_byte(input logic [7:0] b, output logic ackd);
        send_bits(b, 8);
        bm_sda = 1'b1; qw(); scl = 1'b1; qw(); ackd = ~line; qw(); scl = 1'b0; qw();
    endtask
    task automatic recv_byte(input logic ack_lvl, output logic [7:0] b);
        bm_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1'b1; qw(); b[i] = line; qw(); scl = 1'b0;
        end
        qw(); bm_sda = ack_lvl; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask
    task automatic set_addr(input logic [15:0] a, input string tag);
        logic k;
        bus_start();
        send_byte(8'hA4, k); chk(k, {tag, " R2 dev ack"}, k, 1);
        send_byte(a[15:8], k); chk(k, {tag, " R5 hi ack"}, k, 1);
        send_byte(a[7:0], k); chk(k, {tag, " R5 lo ack"}, k, 1);
    endtask
    task automatic read_one(input logic [7:0] exp, input string tag);
        logic k; logic [7:0] d;
        bus_start();
        send_byte(8'hA5, k); chk(k, {tag, " R2 read ack"}, k, 1);
        recv_byte(1'b1, d); chk(d == exp, tag, d, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        chk(wr_req == 1'b0, "R6 reset wr_req", wr_req, 0);
    endtask

    task automatic t_byte_write();
        logic k;
        set_addr(16'h1234, "bw");
        send_byte(8'hA5, k); chk(k, "R6 data ack", k, 1);
        bus_stop();
        chk(wr_cnt == 1, "R6 write count", wr_cnt, 1);
        chk(wa_log[0] == 16'h1234, "R6 write addr", wa_log[0], 16'h1234);
        chk(mval(16'h1234) == 8'hA5, "R6 write data", mval(16'h1234), 8'hA5);
    endtask

    task automatic t_cur_read();
        read_one(fill(16'h1235), "R8 current read");
    endtask

    task automatic t_abort();
        logic k;
        bus_start();
        send_byte(8'hA4, k); chk(k, "R1 abort dev ack", k, 1);
        send_bits(8'h77, 3);
        read_one(fill(16'h1236), "R1 restart after abort");
    endtask

    task automatic t_random();
        set_addr(16'h0100, "rr");
        read_one(fill(16'h0100), "R9 random read");
        set_addr(16'h1234, "rr2");
        read_one(8'hA5, "R9 random read of written byte");
    endtask

    task automatic t_seq();
        logic k; logic [7:0] d;
        logic [15:0] a [4] = '{16'hFFFE, 16'hFFFF, 16'h0000, 16'h0001};
        set_addr(16'hFFFE, "sq");
        bus_start();
        send_byte(8'hA5, k); chk(k, "R10 read ack", k, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i == 3, d);
            chk(d == fill(a[i]), "R10 sequential byte", d, fill(a[i]));
        end
        bm_sda = 1'b1;
        for (int i = 0; i < 9; i++) begin
            qw(); scl = 1'b1; qw();
            chk(line == 1'b1, "R11 released after nack", line, 1);
            qw(); scl = 1'b0; qw();
        end
        bus_stop();
    endtask

    task automatic t_page_wrap();
        logic k;
        int base = wr_cnt;
        set_addr(16'h207E, "pw");
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hC0 + 8'(i), k); chk(k, "R7 data ack", k, 1);
        end
        bus_stop();
        chk(wa_log[base] == 16'h207E, "R7 first", wa_log[base], 16'h207E);
        chk(wa_log[base+1] == 16'h207F, "R7 second", wa_log[base+1], 16'h207F);
        chk(wa_log[base+2] == 16'h2000, "R7 wrapped", wa_log[base+2], 16'h2000);
        set_addr(16'h2000, "pw2");
        read_one(8'hC2, "R7 wrapped data");
    endtask

    task automatic t_mismatch();
        logic k;
        int base = wr_cnt;
        bus_start();
        send_byte(8'hA2, k); chk(!k, "R3 mismatch nack", k, 0);
        send_byte(8'h00, k); chk(!k, "R3 ignored byte", k, 0);
        send_byte(8'h11, k); chk(!k, "R3 ignored byte 2", k, 0);
        bus_stop();
        chk(wr_cnt == base, "R3 no write", wr_cnt, base);
    endtask

    task automatic t_busy();
        logic k;
        busy = 1'b1;
        bus_start();
        send_byte(8'hA4, k); chk(!k, "R4 busy nack", k, 0);
        bus_stop();
        busy = 1'b0;
        set_addr(16'h0300, "R4 after busy");
        read_one(fill(16'h0300), "R4 read after busy");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_byte_write();
        t_cur_read();
        t_abort();
        t_random();
        t_seq();
        t_page_wrap();
        t_mismatch();
        t_busy();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule